// File: doc/BRIEF.md
# Audio Port Control and Status Registers

This block holds the software-visible control word and the error status of an audio serial port. Software reaches the control word through three neighbouring addresses. One overwrites it, one ORs a value into it, and one clears the bits that the value marks. Because of the last two, a driver can flip a single enable without a read-modify-write sequence. The same three-address scheme covers the status word. There, only the clearing address has an effect, and it acknowledges sticky error flags.

The FIFO and serializer sit outside this block. They report through three inputs: a busy level, an underflow pulse and an overflow pulse. The block latches each error pulse into a flag that stays set until software acknowledges it. It raises an interrupt while an error is pending and the error interrupt enable bit is on. The soft reset, clock gate and run bits leave the block as separate outputs that drive the rest of the port. The whole control word is also available as one output.

The bus is a single synchronous port. A write takes effect at the clock edge where it is presented. Read data appears one clock after the read request and holds until the next read.

Top module: `aport_csr`

## Requirements
- R1: After reset the control word is 0xC000_0000, so the soft reset (bit 31) and clock gate (bit 30) bits are 1 and every other bit is 0. Both error flags are clear and irq_o is low.
- R2: A write to byte address 0x00 replaces the whole control word with wdata.
- R3: A write to byte address 0x04 ORs wdata into the control word. Bits that are 0 in wdata are left unchanged.
- R4: A write to byte address 0x08 clears every control bit that is 1 in wdata. All other bits are left unchanged.
- R5: A pulse on fifo_uflow_i sets the underflow flag (status bit 1), and a pulse on fifo_oflow_i sets the overflow flag (status bit 2). Each flag stays set until software clears it.
- R6: A write to byte address 0x18 clears each error flag whose status bit is 1 in wdata. Writes to 0x10 and 0x14 leave the flags unchanged.
- R7: If an error pulse arrives in the same cycle as a software clear of that flag, the flag ends up set.
- R8: irq_o is high exactly when control bit 1 (error interrupt enable) is 1 and at least one error flag is set.
- R9: srst_o, cgate_o and run_o follow control bits 31, 30 and 0. ctrl_o carries the whole control word.
- R10: Read data appears on rdata one clock after rd_en. Reads of 0x00, 0x04 and 0x08 all return the control word. Reads of 0x10, 0x14 and 0x18 return the status word: busy_i in bit 0 (sampled in the read cycle), underflow in bit 1, overflow in bit 2, and zeros elsewhere.
- R11: A read of any other address, including misaligned ones, returns zero. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| busy_i | input | 1 | Port busy level from the serializer |
| fifo_uflow_i | input | 1 | FIFO underflow event pulse |
| fifo_oflow_i | input | 1 | FIFO overflow event pulse |
| ctrl_o | output | 32 | Full control word |
| srst_o | output | 1 | Soft reset request (control bit 31) |
| cgate_o | output | 1 | Clock gate request (control bit 30) |
| run_o | output | 1 | Run enable (control bit 0) |
| irq_o | output | 1 | Error interrupt |

## Verification
The hardest case to reach is a software acknowledge and a hardware error pulse landing in the same clock. The bench reaches it by driving the clearing write and the pulse together on the same falling edge, so both are sampled at one rising edge. It then reads the status word back to see which side won. The flags themselves are covered by a sweep over every combination of pending underflow, pending overflow, acknowledge mask and interrupt enable. After each step the bench checks irq_o and the status read-back against values it computes from that combination.

// File: rtl/aport_csr_pkg.sv
// Shared address map, bit positions and access kinds for the audio port
// control/status register block. Bit positions are fixed by the port logic
// that decodes the control word; widths derive from DATA_W.
package aport_csr_pkg;

    localparam int DATA_W      = 32;
    localparam int SUB_W       = 4;    // low address bits selecting the alias
    localparam int REGION_CTRL = 0;    // addr[.. : 4] value for the control word
    localparam int REGION_STAT = 1;    // addr[.. : 4] value for the status word

    // alias offsets inside a region
    localparam logic [SUB_W-1:0] SUB_PLAIN = 4'h0;
    localparam logic [SUB_W-1:0] SUB_SET   = 4'h4;
    localparam logic [SUB_W-1:0] SUB_CLR   = 4'h8;

    // control word bit positions
    localparam int CB_RUN   = 0;
    localparam int CB_ERRIE = 1;
    localparam int CB_CGATE = 30;
    localparam int CB_SRST  = 31;

    // status word bit positions
    localparam int SB_BUSY  = 0;
    localparam int SB_UFLOW = 1;
    localparam int SB_OFLOW = 2;

    localparam int NUM_ERR  = 2;        // index 0 = underflow, 1 = overflow

    localparam logic [DATA_W-1:0] CTRL_RST =
        (DATA_W'(1) << CB_SRST) | (DATA_W'(1) << CB_CGATE);

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_PLAIN = 2'd1,
        ACC_SET   = 2'd2,
        ACC_CLR   = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/aport_addr_decode.sv
// Address decoder. Splits a byte address into a region (control or status)
// and an alias kind (plain, set, clear). Assumes the region index lies in the
// address bits above SUB_W; any address off the six mapped ones is ACC_NONE.
module aport_addr_decode
    import aport_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic              hit_ctrl,
    output logic              hit_stat
);

    localparam int REG_W = ADDR_W - SUB_W;

    logic [REG_W-1:0] region;
    logic [SUB_W-1:0] sub;

    assign region = addr[ADDR_W-1:SUB_W];
    assign sub    = addr[SUB_W-1:0];

    // classify the alias from the low address bits
    always_comb begin
        unique case (sub)
            SUB_PLAIN: kind = ACC_PLAIN;
            SUB_SET:   kind = ACC_SET;
            SUB_CLR:   kind = ACC_CLR;
            default:   kind = ACC_NONE;
        endcase
    end

    // pick a register only for a mapped alias in a mapped region
    always_comb begin
        hit_ctrl = (kind != ACC_NONE) && (region == REG_W'(REGION_CTRL));
        hit_stat = (kind != ACC_NONE) && (region == REG_W'(REGION_STAT));
    end

endmodule

// File: rtl/aport_alias_reg.sv
// Register with plain, OR-in and bit-clear write paths. Assumes at most one
// access kind per cycle (guaranteed by the single address).
module aport_alias_reg
    import aport_csr_pkg::*;
#(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  acc_kind_e    kind,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // apply the selected write form at the clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (we) begin
            unique case (kind)
                ACC_PLAIN: q <= wdata;
                ACC_SET:   q <= q | wdata;
                ACC_CLR:   q <= q & ~wdata;
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/aport_sticky_flags.sv
// Bank of sticky event flags. A set pulse latches a flag; a clear request
// drops it; a set in the same cycle as a clear leaves the flag set.
module aport_sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // latch event, honour acknowledge only when no new event arrives
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= set_i[i] | (q[i] & ~clr_i[i]);
        end
    end

endmodule

// File: rtl/aport_csr.sv
// Control and status register block of an audio serial port. Holds the
// control word (three-address access), the sticky FIFO error flags and the
// error interrupt. Assumes single-cycle error pulses and a level busy input.
module aport_csr
    import aport_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy_i,
    input  logic              fifo_uflow_i,
    input  logic              fifo_oflow_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              srst_o,
    output logic              cgate_o,
    output logic              run_o,
    output logic              irq_o
);

    acc_kind_e           kind;
    logic                hit_ctrl;
    logic                hit_stat;
    logic [DATA_W-1:0]   ctrl_q;
    logic [NUM_ERR-1:0]  err_set;
    logic [NUM_ERR-1:0]  err_clr;
    logic [NUM_ERR-1:0]  err_q;
    logic [DATA_W-1:0]   stat_word;

    aport_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (addr),
        .kind     (kind),
        .hit_ctrl (hit_ctrl),
        .hit_stat (hit_stat)
    );

    aport_alias_reg #(.W(DATA_W), .RST_VAL(CTRL_RST)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && hit_ctrl),
        .kind  (kind),
        .wdata (wdata),
        .q     (ctrl_q)
    );

    // hardware events and software acknowledge for the error flags
    always_comb begin
        err_set = {fifo_oflow_i, fifo_uflow_i};
        err_clr = '0;
        if (wr_en && hit_stat && kind == ACC_CLR)
            err_clr = {wdata[SB_OFLOW], wdata[SB_UFLOW]};
    end

    aport_sticky_flags #(.N(NUM_ERR)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_set),
        .clr_i (err_clr),
        .q     (err_q)
    );

    // assemble the status word seen by reads
    always_comb begin
        stat_word           = '0;
        stat_word[SB_BUSY]  = busy_i;
        stat_word[SB_UFLOW] = err_q[0];
        stat_word[SB_OFLOW] = err_q[1];
    end

    // registered read port, holds its value between reads
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata <= '0;
        else if (rd_en) begin
            if (hit_ctrl)      rdata <= ctrl_q;
            else if (hit_stat) rdata <= stat_word;
            else               rdata <= '0;
        end
    end

    assign ctrl_o  = ctrl_q;
    assign srst_o  = ctrl_q[CB_SRST];
    assign cgate_o = ctrl_q[CB_CGATE];
    assign run_o   = ctrl_q[CB_RUN];
    assign irq_o   = ctrl_q[CB_ERRIE] & (|err_q);

endmodule

// File: rtl/aport_csr_chk.sv
// Property checker for aport_csr, attached through bind below.
module aport_csr_chk
    import aport_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              fifo_uflow_i,
    input logic              fifo_oflow_i,
    input logic [DATA_W-1:0] ctrl_o,
    input logic              irq_o,
    input logic [NUM_ERR-1:0] err_q
);

    localparam logic [ADDR_W-1:0] A_CSET = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] A_CCLR = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] A_SPLN = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] A_SCLR = ADDR_W'(8'h18);

    // R1
    rst_value_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (ctrl_o == CTRL_RST && err_q == '0));

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CSET) |=> ((ctrl_o & $past(wdata)) == $past(wdata)));

    // R4
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CCLR) |=> ((ctrl_o & $past(wdata)) == '0));

    // R5
    uflow_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_uflow_i |=> err_q[0]);

    // R5
    uflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q[0] && !(wr_en && addr == A_SCLR)) |=> err_q[0]);

    // R6
    stat_plain_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SPLN && !fifo_uflow_i && !fifo_oflow_i) |=> $stable(err_q));

    // R7
    oflow_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_oflow_i && wr_en && addr == A_SCLR) |=> err_q[1]);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[CB_ERRIE] |-> !irq_o);

    // R8
    irq_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[CB_ERRIE] && err_q != '0) |-> irq_o);

endmodule

bind aport_csr aport_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .fifo_uflow_i (fifo_uflow_i),
    .fifo_oflow_i (fifo_oflow_i),
    .ctrl_o       (ctrl_o),
    .irq_o        (irq_o),
    .err_q        (err_q)
);

// File: tb/aport_csr_bench.sv
`timescale 1ns/1ps
module aport_csr_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy_i = 1'b0;
    logic        fifo_uflow_i = 1'b0;
    logic        fifo_oflow_i = 1'b0;
    logic [31:0] ctrl_o;
    logic        srst_o, cgate_o, run_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] model;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    aport_csr u_aport_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy_i(busy_i),
        .fifo_uflow_i(fifo_uflow_i), .fifo_oflow_i(fifo_oflow_i),
        .ctrl_o(ctrl_o), .srst_o(srst_o), .cgate_o(cgate_o), .run_o(run_o),
        .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write with optional simultaneous error pulses; inputs change on negedge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d,
                          input logic uf, input logic of);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; fifo_uflow_i = uf; fifo_oflow_i = of;
        @(negedge clk);
        wr_en = 1'b0; fifo_uflow_i = 1'b0; fifo_oflow_i = 1'b0;
    endtask

    task automatic pulse(input logic uf, input logic of);
        @(negedge clk);
        fifo_uflow_i = uf; fifo_oflow_i = of;
        @(negedge clk);
        fifo_uflow_i = 1'b0; fifo_oflow_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic check_ctrl(input string req, input int alias_sel);
        logic [31:0] r;
        bus_rd(8'(alias_sel * 4), r);
        chk(req, r, model);
        chk("R9 ctrl_o", ctrl_o, model);
        chk("R9 pins", {29'd0, srst_o, cgate_o, run_o}, {29'd0, model[31], model[30], model[0]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        model = 32'hC000_0000;
        check_ctrl("R1 ctrl", 0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        bus_rd(8'h10, rv);
        chk("R1 status", rv, 32'd0);

        // R3 walking-one OR-in, R4 walking-one clear, read through all aliases (R10)
        for (int b = 0; b < 32; b++) begin
            bus_wr(8'h04, 32'd1 << b, 1'b0, 1'b0);
            model = model | (32'd1 << b);
            check_ctrl("R3 set alias", b % 3);
        end
        for (int b = 0; b < 32; b++) begin
            bus_wr(8'h08, 32'd1 << b, 1'b0, 1'b0);
            model = model & ~(32'd1 << b);
            check_ctrl("R4 clear alias", (b + 1) % 3);
        end

        // R2 plain writes, then R3/R4 multi-bit patterns
        for (int p = 0; p < 8; p++) begin
            logic [31:0] pat;
            pat = (32'h9E37_79B9 * (p + 1)) ^ (32'h0F0F_0F0F << p);
            bus_wr(8'h00, pat, 1'b0, 1'b0);
            model = pat;
            check_ctrl("R2 plain write", p % 3);
            bus_wr(8'h04, ~pat & 32'h00FF_00FF, 1'b0, 1'b0);
            model = model | (~pat & 32'h00FF_00FF);
            check_ctrl("R3 pattern", 1);
            bus_wr(8'h08, pat ^ 32'h5555_AAAA, 1'b0, 1'b0);
            model = model & ~(pat ^ 32'h5555_AAAA);
            check_ctrl("R4 pattern", 2);
        end

        // R11 unmapped writes leave the control word, unmapped reads give zero
        bus_wr(8'h00, 32'h1234_5678, 1'b0, 1'b0);
        model = 32'h1234_5678;
        foreach (model[k]) begin end
        for (int u = 0; u < 6; u++) begin
            logic [7:0] ua;
            ua = (u == 0) ? 8'h0C : (u == 1) ? 8'h1C : (u == 2) ? 8'h20 :
                 (u == 3) ? 8'hFF : (u == 4) ? 8'h02 : 8'h44;
            bus_wr(ua, 32'hFFFF_FFFF, 1'b0, 1'b0);
            check_ctrl("R11 unmapped write", 0);
            bus_rd(ua, rv);
            chk("R11 unmapped read", rv, 32'd0);
        end

        // R10 busy bit is sampled live on status reads
        busy_i = 1'b1;
        bus_rd(8'h14, rv);
        chk("R10 busy read", rv, 32'd1);
        busy_i = 1'b0;
        bus_rd(8'h18, rv);
        chk("R10 idle read", rv, 32'd0);

        // R5/R6/R8 exhaustive sweep: enable x pending flags x acknowledge mask
        for (int en = 0; en < 2; en++) begin
            bus_wr(8'h00, 32'(en) << 1, 1'b0, 1'b0);
            for (int fl = 0; fl < 4; fl++) begin
                for (int m = 0; m < 4; m++) begin
                    logic [1:0] exp_f;
                    bus_wr(8'h18, 32'h6, 1'b0, 1'b0);
                    pulse(fl[0], fl[1]);
                    pulse(1'b0, 1'b0);
                    exp_f = fl[1:0];
                    bus_rd(8'h10, rv);
                    chk("R5 flags latched", rv, {29'd0, exp_f, 1'b0});
                    chk("R8 irq pending", {31'd0, irq_o}, {31'd0, (en == 1) && (exp_f != 0)});
                    bus_wr(8'h10, 32'hFFFF_FFFF, 1'b0, 1'b0);
                    bus_wr(8'h14, 32'hFFFF_FFFF, 1'b0, 1'b0);
                    bus_rd(8'h14, rv);
                    chk("R6 plain/set ignored", rv, {29'd0, exp_f, 1'b0});
                    bus_wr(8'h18, 32'(m) << 1, 1'b0, 1'b0);
                    exp_f = exp_f & ~m[1:0];
                    bus_rd(8'h18, rv);
                    chk("R6 acknowledge", rv, {29'd0, exp_f, 1'b0});
                    chk("R8 irq after ack", {31'd0, irq_o}, {31'd0, (en == 1) && (exp_f != 0)});
                end
            end
        end

        // R7 event and acknowledge in the same cycle
        bus_wr(8'h18, 32'h6, 1'b1, 1'b1);
        bus_rd(8'h10, rv);
        chk("R7 both set win", rv, 32'h6);
        bus_wr(8'h18, 32'h6, 1'b1, 1'b0);
        bus_rd(8'h10, rv);
        chk("R7 uflow wins, oflow cleared", rv, 32'h2);
        bus_wr(8'h18, 32'h6, 1'b0, 1'b1);
        bus_rd(8'h10, rv);
        chk("R7 oflow wins, uflow cleared", rv, 32'h4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule